// File: doc/BRIEF.md
# Single-Channel Word Block Mover with FIFO Throttle

The block moves a run of 32-bit words from a local source region to a destination write FIFO. Software or a neighbouring controller supplies a source address, a destination address and a word count, then pulses `start`. For each word the mover raises a one-cycle read request at the current source address. In the following cycle it raises a one-cycle write request at the current destination address. Both addresses then advance by four bytes. When the last word has been written it pulses `done`.

Issue is paced by the fill level of the destination FIFO, which the mover sees only as a level input. When the level goes above half the FIFO depth, issue stops. It resumes only after the level falls below a quarter of the depth, so the mover does not toggle on and off around a single threshold. In demand mode each source fetch also waits for an active-low external request line, which passes through a two-flop synchronizer first. Each fetch in that mode produces an acknowledge pulse.

The sequencer has five states. IDLE waits for `start`. CHECK waits for issue permission. READ issues the source fetch. WRITE issues the destination store and decrements the count. DONE pulses completion. The transitions are:
- IDLE→CHECK on an accepted start with a legal count.
- IDLE→DONE on a start whose count is zero or above the cap.
- CHECK→READ when neither the throttle nor the demand gate holds issue back.
- READ→WRITE always.
- WRITE→CHECK while words remain.
- WRITE→DONE after the last word.
- DONE→IDLE always.

Top module: `blk_mover`

## Requirements
- R1: After reset the mover is idle. `busy`, `rd_req`, `wr_req`, `dack` and `done` are all low.
- R2: `start` is only taken in IDLE. A `start` raised while the mover is busy is ignored: the running block keeps its addresses and count.
- R3: Each word is one `rd_req` cycle at the source address, followed in the very next cycle by one `wr_req` cycle at the destination address. The two requests are never high in the same cycle.
- R4: Both start addresses are forced to word alignment (address bits 1:0 become zero). Each address advances by 4 after every word.
- R5: Only address bits 24:0 count. A carry out of bit 24 wraps the address to the base of the same 32MB region, and bits 31:25 never change during a block.
- R6: A count of zero, or a count above 1,048,575 words, moves nothing. `done` is high in the first cycle after the start edge, and no request is issued.
- R7: `done` is a single-cycle pulse that follows the write of the last word. The number of words written equals the requested count.
- R8: No read is issued at a clock edge where the FIFO level is above half the FIFO depth.
- R9: After the level has gone above half the depth, issue stays blocked until a clock edge sees the level below a quarter of the depth. Levels between a quarter and half keep the previous throttle state. The throttle is cleared when a block starts.
- R10: `demand_en` is captured at start. In demand mode a read is issued only at an edge where the synchronized request is active, meaning `dreq_n` was low two edges earlier. Outside demand mode `dreq_n` has no effect.
- R11: In demand mode `dack` is high in exactly the cycles in which `rd_req` is high. Outside demand mode `dack` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for a block |
| src_addr | input | 32 | Source byte address |
| dst_addr | input | 32 | Destination byte address |
| word_cnt | input | 22 | Number of words to move |
| demand_en | input | 1 | Enables request-gated fetches |
| dreq_n | input | 1 | External fetch request, active low, asynchronous |
| fifo_level | input | 5 | Current destination FIFO fill level |
| rd_req | output | 1 | One-cycle source word read request |
| rd_addr | output | 32 | Source word address |
| wr_req | output | 1 | One-cycle destination word write request |
| wr_addr | output | 32 | Destination word address |
| dack | output | 1 | Acknowledge pulse per demand-mode fetch |
| busy | output | 1 | Mover is not in IDLE |
| done | output | 1 | Block complete pulse |

## Verification
A wrong state or transition shows at the ports within a few cycles:
- A stuck or skipped state shows as a `wr_req` missing after a `rd_req`, or as a `done` pulse whose word total differs from the requested count.
- A corrupted address register shows on the very next request, as a wrong `rd_addr` or `wr_addr`. Region wrapping is checked by placing blocks just below a 32MB boundary.
- A throttle or synchronizer holding the wrong value shows as a read issued in a cycle where the level history or the delayed request forbids it.
- A throttle that never releases shows as a block that never completes.

// File: rtl/blkmv_pkg.sv
package blkmv_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_READ  = 3'd2,
        S_WRITE = 3'd3,
        S_DONE  = 3'd4
    } mv_state_e;

endpackage

// File: rtl/blkmv_sync.sv
module blkmv_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/blkmv_throttle.sv
module blkmv_throttle #(
    parameter int DEPTH = 16,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [LVL_W-1:0] level,
    output logic             blocked
);
    localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);
    localparam logic [LVL_W-1:0] QTR_LVL  = LVL_W'(DEPTH / 4);

    logic hold_q;
    logic over_half;
    logic under_qtr;

    assign over_half = level > HALF_LVL;
    assign under_qtr = level < QTR_LVL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (clr) begin
            hold_q <= 1'b0;
        end else if (over_half) begin
            hold_q <= 1'b1;
        end else if (under_qtr) begin
            hold_q <= 1'b0;
        end
    end

    assign blocked = hold_q | over_half;

    AST_THR_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !over_half && !under_qtr) |=> $stable(hold_q)); // R9
    AST_THR_ENGAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && over_half) |=> hold_q); // R8
    AST_THR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hold_q); // R9

endmodule

// File: rtl/blkmv_addr.sv
module blkmv_addr #(
    parameter int ADDR_W = 32,
    parameter int WRAP_W = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    localparam int IDX_W = WRAP_W - 2;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_next;

    assign idx_next = addr_q[WRAP_W-1:2] + IDX_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr & ALIGN_MASK;
        end else if (step) begin
            addr_q <= {addr_q[ADDR_W-1:WRAP_W], idx_next, 2'b00};
        end
    end

    assign addr = addr_q;

    AST_REGION_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> addr_q[ADDR_W-1:WRAP_W] == $past(addr_q[ADDR_W-1:WRAP_W])); // R5
    AST_REGION_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (&addr_q[WRAP_W-1:2])) |=> addr_q[WRAP_W-1:0] == '0); // R5
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        addr_q[1:0] == 2'b00); // R4

endmodule

// File: rtl/blk_mover.sv
module blk_mover
    import blkmv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WRAP_W     = 25,
    parameter int CNT_W      = 22,
    parameter int BLK_W      = 20,
    parameter int FIFO_DEPTH = 16,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    input  logic              demand_en,
    input  logic              dreq_n,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              dack,
    output logic              busy,
    output logic              done
);
    localparam logic [CNT_W-1:0] MAX_WORDS = CNT_W'((64'd1 << BLK_W) - 64'd1);
    localparam logic [BLK_W-1:0] LAST_ONE  = BLK_W'(1);
    localparam int               HALF_INT  = FIFO_DEPTH / 2;

    mv_state_e state_q, state_d;

    logic [BLK_W-1:0] remain_q;
    logic             dem_q;
    logic             accept;
    logic             cnt_legal;
    logic             thr_blocked;
    logic             dreq_sync_n;
    logic             dreq_act;
    logic             issue_ok;
    logic             step_addr;

    assign accept    = (state_q == S_IDLE) && start;
    assign cnt_legal = (word_cnt != '0) && (word_cnt <= MAX_WORDS);
    assign dreq_act  = ~dreq_sync_n;
    assign issue_ok  = !thr_blocked && (!dem_q || dreq_act);
    assign step_addr = (state_q == S_WRITE);

    blkmv_sync #(
        .STAGES (2),
        .RST_VAL(1'b1)
    ) u_dreq_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(dreq_n),
        .q_sync (dreq_sync_n)
    );

    blkmv_throttle #(
        .DEPTH(FIFO_DEPTH),
        .LVL_W(LVL_W)
    ) u_throttle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .level  (fifo_level),
        .blocked(thr_blocked)
    );

    blkmv_addr #(
        .ADDR_W(ADDR_W),
        .WRAP_W(WRAP_W)
    ) u_src_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_addr(src_addr),
        .step     (step_addr),
        .addr     (rd_addr)
    );

    blkmv_addr #(
        .ADDR_W(ADDR_W),
        .WRAP_W(WRAP_W)
    ) u_dst_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_addr(dst_addr),
        .step     (step_addr),
        .addr     (wr_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Block bookkeeping: remaining words and captured mode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
            dem_q    <= 1'b0;
        end else if (accept) begin
            remain_q <= cnt_legal ? BLK_W'(word_cnt) : '0;
            dem_q    <= demand_en;
        end else if (state_q == S_WRITE) begin
            remain_q <= remain_q - LAST_ONE;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = cnt_legal ? S_CHECK : S_DONE;
                end
            end
            S_CHECK: begin
                if (issue_ok) begin
                    state_d = S_READ;
                end
            end
            S_READ: begin
                state_d = S_WRITE;
            end
            S_WRITE: begin
                state_d = (remain_q == LAST_ONE) ? S_DONE : S_CHECK;
            end
            S_DONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Output decode
    always_comb begin
        rd_req = 1'b0;
        wr_req = 1'b0;
        dack   = 1'b0;
        done   = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            S_IDLE:  busy = 1'b0;
            S_CHECK: ;
            S_READ: begin
                rd_req = 1'b1;
                dack   = dem_q;
            end
            S_WRITE: wr_req = 1'b1;
            S_DONE:  done   = 1'b1;
            default: busy   = 1'b0;
        endcase
    end

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req)); // R3
    AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> wr_req); // R3
    AST_NO_ISSUE_OVER_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (int'($past(fifo_level)) <= HALF_INT)); // R8
    AST_DEMAND_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && dem_q) |-> $past(dreq_act)); // R10
    AST_DACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> !dack); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_BUSY_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step_addr) |=> $stable(remain_q)); // R2

endmodule

// File: tb/test_blk_mover.sv
module test_blk_mover;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int HALF       = DEPTH / 2;
    localparam int QTR        = DEPTH / 4;
    localparam int MAXW       = (1 << 20) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [21:0] cnt_i = '0;
    logic        dem_i = 1'b0;
    logic        dreq_n = 1'b1;
    logic [4:0]  lvl = '0;
    logic        rd_req, wr_req, dack, busy, done;
    logic [31:0] rd_addr, wr_addr;

    int nchk = 0;
    int nfail = 0;
    logic thr_m = 1'b0;
    logic s1_m = 1'b1;
    logic s2_m = 1'b1;
    logic dem_m = 1'b0;
    logic last_allowed = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blk_mover i_blk_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_i),
        .dst_addr(dst_i), .word_cnt(cnt_i), .demand_en(dem_i), .dreq_n(dreq_n),
        .fifo_level(lvl), .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req),
        .wr_addr(wr_addr), .dack(dack), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt_addr(input logic [31:0] a);
        logic [24:0] low;
        low = a[24:0] + 25'd4;
        return {a[31:25], low};
    endfunction

    // One clock: model the throttle and synchronizer against the edge, then sample at negedge.
    task automatic tick(input bit st);
        logic allowed;
        allowed = !(thr_m || (int'(lvl) > HALF)) && (!dem_m || !s2_m);
        @(posedge clk);
        if (st) thr_m = 1'b0;
        else if (int'(lvl) > HALF) thr_m = 1'b1;
        else if (int'(lvl) < QTR) thr_m = 1'b0;
        s2_m = s1_m;
        s1_m = dreq_n;
        @(negedge clk);
        last_allowed = allowed;
    endtask

    // mode: 0 level zero, 1 random level, 2 directed hysteresis pattern
    // dmode: 0 dreq high, 1 random dreq, 2 dreq low
    task automatic run_block(input logic [31:0] s, input logic [31:0] d, input int cnt,
                             input bit dem, input int mode, input int dmode, input bit inj);
        logic [31:0] ers, ewr;
        int words;
        bit prev_rd;
        bit finished;
        src_i = s; dst_i = d; cnt_i = 22'(cnt); dem_i = dem; start = 1'b1;
        lvl = (mode == 2) ? 5'(DEPTH) : 5'd0;
        tick(1'b1);
        dem_m = dem;
        start = 1'b0;
        if (cnt == 0 || cnt > MAXW) begin
            chk(done == 1'b1, "R6 done after start", 32'(done), 32'd1);
            chk(rd_req == 1'b0 && wr_req == 1'b0, "R6 no request", 32'(rd_req), 32'd0);
            tick(1'b0);
            chk(done == 1'b0 && busy == 1'b0, "R6 back to idle", 32'(done), 32'd0);
            return;
        end
        ers = s & ~32'd3;
        ewr = d & ~32'd3;
        words = 0;
        prev_rd = 1'b0;
        finished = 1'b0;
        for (int c = 0; c < 3000 && !finished; c++) begin
            if (mode == 1) lvl = 5'($urandom_range(0, DEPTH));
            else if (mode == 2) lvl = (c < 6) ? 5'(DEPTH) : (c < 16) ? 5'(HALF) : 5'd0;
            if (dmode == 1) dreq_n = 1'($urandom_range(0, 1));
            else if (dmode == 2) dreq_n = 1'b0;
            else dreq_n = 1'b1;
            if (inj && c == 3) begin
                start = 1'b1; src_i = ~s; dst_i = ~d; cnt_i = 22'd0;
            end else begin
                start = 1'b0;
            end
            tick(1'b0);
            if (prev_rd) chk(wr_req == 1'b1, "R3 write follows read", 32'(wr_req), 32'd1);
            chk(!(rd_req && wr_req), "R3 exclusive", {rd_req, wr_req}, 32'd0);
            if (rd_req) begin
                chk(last_allowed == 1'b1, dem ? "R10 fetch gated" : "R8/R9 throttle", 32'(last_allowed), 32'd1);
                chk(rd_addr == ers, "R4/R5 rd_addr", rd_addr, ers);
                chk(dack == dem, "R11 dack with fetch", 32'(dack), 32'(dem));
                if (mode == 2 && c < 16) chk(1'b0, "R9 issue inside band", 32'd1, 32'd0);
            end else begin
                chk(dack == 1'b0, "R11 dack idle", 32'(dack), 32'd0);
            end
            if (wr_req) begin
                chk(wr_addr == ewr, "R4/R5 wr_addr", wr_addr, ewr);
                ers = nxt_addr(ers);
                ewr = nxt_addr(ewr);
                words++;
            end
            prev_rd = rd_req;
            if (done) begin
                finished = 1'b1;
                chk(words == cnt, "R7 word total", 32'(words), 32'(cnt));
                if (inj) chk(words == cnt, "R2 busy start ignored", 32'(words), 32'(cnt));
                start = 1'b0;
                tick(1'b0);
                chk(done == 1'b0 && busy == 1'b0, "R7 single pulse", 32'(done), 32'd0);
            end
        end
        if (!finished) chk(1'b0, "R7 block never finished", 32'(words), 32'(cnt));
        start = 1'b0;
        lvl = 5'd0;
        dreq_n = 1'b1;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h1234_ABCD);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && rd_req == 1'b0 && wr_req == 1'b0 && done == 1'b0 && dack == 1'b0,
            "R1 reset state", {busy, rd_req, wr_req, done, dack}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after reset", 32'(busy), 32'd0);

        run_block(32'h1000_0003, 32'h2000_0001, 5, 1'b0, 0, 0, 1'b0);       // R4 align
        run_block(32'h05FF_FFF8, 32'h07FF_FFFC, 4, 1'b0, 0, 0, 1'b0);       // R5 wrap
        run_block(32'h0000_0100, 32'h0000_0200, 0, 1'b0, 0, 0, 1'b0);      // R6 zero
        run_block(32'h0000_0100, 32'h0000_0200, 1 << 20, 1'b0, 0, 0, 1'b0); // R6 over cap
        run_block(32'h0000_0100, 32'h0000_0200, (1 << 21) + 5, 1'b0, 0, 0, 1'b0);
        run_block(32'h0300_0000, 32'h0400_0000, 6, 1'b0, 2, 0, 1'b0);       // R9 hysteresis
        run_block(32'h0000_4000, 32'h0000_8000, 6, 1'b0, 0, 1, 1'b1);       // R2, R10 ignored
        run_block(32'h0000_4000, 32'h0000_8000, 8, 1'b1, 0, 1, 1'b0);       // R10, R11
        run_block(32'h0000_5000, 32'h0000_9000, 3, 1'b1, 0, 2, 1'b0);       // R11
        for (int i = 0; i < 16; i++) begin
            logic [31:0] s, d;
            s = $urandom();
            d = $urandom();
            if (i % 3 == 0) s[24:0] = 25'h1FF_FFF0;
            if (i % 4 == 1) d[24:0] = 25'h1FF_FFE8;
            run_block(s, d, int'($urandom_range(1, 24)), 1'($urandom_range(0, 1)),
                      int'($urandom_range(0, 1)), int'($urandom_range(1, 2)), 1'b0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int cycles;
        cycles = 0;
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        nchk++;
        nfail++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=0", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule